// File: doc/BRIEF.md
# Capability Program Counter Fetch Guard

This block sits beside the fetch stage of a core whose program counter is a capability. The capability carries a validity tag, a seal flag, permission bits, a decoded lower bound, a decoded upper bound and the address used as the PC. The block holds that program-counter capability and a saved exception capability. Whenever the core presents a fetch, the block checks the current capability's tag and checks that the whole instruction, 2 or 4 bytes long, lies within the bounds. It reports the result as a pair of sub-cause flags.

Jumps and branches load new program-counter capabilities through the load port without any check. A target outside the bounds is caught only when the instruction there is fetched. A fetch fault or an externally requested exception starts a trap. The current capability is saved as the exception capability, and the trap-vector capability is installed. When the fault is a bounds fault, the saved copy loses its tag. This keeps an out-of-range address from ever producing a valid capability, so no representability logic is needed. A return-from-trap installs the saved capability. An untagged capability installed this way faults on its next fetch.

Top module: `cap_fetch_guard`

## Requirements
- R1: Capability vectors are packed from the MSB down as tag, sealed, PW permission bits, top (AW+1 bits), base (AW bits) and address (AW bits, at bit 0). After reset, `pcc_cap` holds the root value: tag 1, sealed 0, all permissions set, base 0, top 2^AW, address RESET_ADDR. `epcc_cap` is all zeros.
- R2: A fetch (`fetch_valid`=1) with an untagged `pcc_cap` raises `fault_tag` and `trap_taken` in the same cycle, with `trap_cause`=0x1C and `trap_tval`=2.
- R3: A fetch with a tagged `pcc_cap` raises `fault_len` (cause 0x1C, tval 1) unless base <= address and address+len <= top. Here len is 4 when `fetch_is32`=1 and 2 otherwise, and the sum is formed without wrap-around.
- R4: The two fault flags are never both set; the tag fault wins over the bounds fault.
- R5: Without `fetch_valid`, no fault flag is raised, whatever the capability holds.
- R6: On the edge after `trap_taken`, `epcc_cap` equals the previous `pcc_cap`, with its address being the trapping address, and `pcc_cap` equals the previous `tvec_cap`.
- R7: When the trap comes from a bounds fault, the saved `epcc_cap` has its tag cleared; on any other trap the tag is kept.
- R8: `exc_req` without a fetch fault traps with `trap_cause`=`exc_code` and `trap_tval`=0. A fetch fault overrides `exc_req`'s cause. With no trap, both cause and tval read 0.
- R9: `mret_req` without a trap sets `ret_taken`. On the next edge `pcc_cap` takes the value of `epcc_cap`, and `epcc_cap` is unchanged.
- R10: A trap takes priority over a return, and a return over `ld_valid`. When only `ld_valid` is active, `ld_cap` is installed unchecked on the next edge. When nothing is active, `pcc_cap` holds its value.
- R11: An untagged trap vector is installed as-is, so every fetch after it traps again with a tag fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | A fetch is presented this cycle |
| fetch_is32 | input | 1 | Fetched instruction is 4 bytes (else 2) |
| ld_valid | input | 1 | Install `ld_cap` as the new PC capability |
| ld_cap | input | 3*AW+PW+3 | PC capability from sequencing, jump or branch |
| exc_req | input | 1 | Exception raised by the current instruction |
| exc_code | input | CAUSE_W | Cause code of that exception |
| mret_req | input | 1 | Return-from-trap request |
| tvec_cap | input | 3*AW+PW+3 | Trap vector capability (direct mode) |
| pcc_cap | output | 3*AW+PW+3 | Current PC capability |
| epcc_cap | output | 3*AW+PW+3 | Saved exception PC capability |
| fault_tag | output | 1 | Fetch tag violation |
| fault_len | output | 1 | Fetch bounds (length) violation |
| trap_taken | output | 1 | Trap entry this cycle |
| ret_taken | output | 1 | Return-from-trap this cycle |
| trap_cause | output | CAUSE_W | Cause code of the trap |
| trap_tval | output | 5 | Capability sub-cause for the trap value register |

## Verification
The bench goes after the exact upper edge of the bounds, where address+len equals top. A design that used `<` there, or checked a 2-byte length for 4-byte fetches, would fault on legal code or let the last instruction run past the bound. It places a region ending at 2^AW and fetches its last word. A design that summed in AW bits would wrap and raise a spurious fault there. It combines an untagged capability with an out-of-range address to catch a design that reports both flags, and it traps through an untagged vector to show the fault loop. It also checks that the saved tag is cleared only on bounds faults, and that trap, return and load requests given together resolve in the stated order.

// File: rtl/cap_fetch_guard_pkg.sv
package cap_fetch_guard_pkg;

  // Exception code shared by every capability-specific fault
  localparam logic [7:0] CAP_EXC_CODE = 8'h1C;

  // Detailed sub-cause values written to the trap value register
  typedef enum logic [4:0] {
    SUBC_NONE   = 5'd0,
    SUBC_LENGTH = 5'd1,
    SUBC_TAG    = 5'd2
  } subcause_e;

endpackage

// File: rtl/cfg_bounds_unit.sv
module cfg_bounds_unit #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] base,
  input  logic [AW:0]   top,
  input  logic          is32,
  output logic          in_bounds
);

  localparam logic [AW:0] LEN_HALF = (AW+1)'(2);
  localparam logic [AW:0] LEN_WORD = (AW+1)'(4);

  // Whole instruction inside [base, top); one guard bit keeps the end from wrapping
  function automatic logic span_fits(input logic [AW-1:0] a,
                                     input logic [AW-1:0] lo,
                                     input logic [AW:0]   hi,
                                     input logic          wide);
    logic [AW:0] start_x;
    logic [AW:0] end_x;
    start_x = {1'b0, a};
    end_x   = start_x + (wide ? LEN_WORD : LEN_HALF);
    return (start_x >= {1'b0, lo}) && (end_x <= hi);
  endfunction

  assign in_bounds = span_fits(addr, base, top, is32);

endmodule

// File: rtl/cfg_fault_sel.sv
module cfg_fault_sel
  import cap_fetch_guard_pkg::*;
#(
  parameter int CAUSE_W = 6
) (
  input  logic               fetch_valid,
  input  logic               cap_tag,
  input  logic               in_bounds,
  input  logic               exc_req,
  input  logic [CAUSE_W-1:0] exc_code,
  input  logic               mret_req,
  output logic               fault_tag,
  output logic               fault_len,
  output logic               trap,
  output logic               ret,
  output logic [CAUSE_W-1:0] cause,
  output logic [4:0]         tval
);

  logic any_fault;
  subcause_e sub;

  always_comb begin
    fault_tag = fetch_valid && !cap_tag;
    fault_len = fetch_valid && cap_tag && !in_bounds;
    any_fault = fault_tag || fault_len;
    trap      = any_fault || exc_req;
    ret       = !trap && mret_req;

    if (fault_tag)      sub = SUBC_TAG;
    else if (fault_len) sub = SUBC_LENGTH;
    else                sub = SUBC_NONE;
    tval = 5'(sub);

    if (any_fault)    cause = CAUSE_W'(CAP_EXC_CODE);
    else if (exc_req) cause = exc_code;
    else              cause = '0;
  end

endmodule

// File: rtl/cfg_cap_regs.sv
module cfg_cap_regs #(
  parameter int              AW         = 32,
  parameter int              PW         = 4,
  parameter logic [AW-1:0]   RESET_ADDR = '0,
  localparam int             CAPW       = 3*AW + PW + 3,
  localparam int             TAG_BIT    = CAPW - 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trap,
  input  logic            ret,
  input  logic            ld_valid,
  input  logic            clear_saved_tag,
  input  logic [CAPW-1:0] ld_cap,
  input  logic [CAPW-1:0] tvec_cap,
  output logic [CAPW-1:0] pcc_q,
  output logic [CAPW-1:0] epcc_q
);

  localparam logic [AW:0]     ROOT_TOP = (AW+1)'(1) << AW;
  localparam logic [CAPW-1:0] ROOT_CAP = {1'b1, 1'b0, {PW{1'b1}}, ROOT_TOP,
                                          {AW{1'b0}}, RESET_ADDR};

  logic [CAPW-1:0] saved_next;

  // Saved copy keeps the trapping address; a bounds fault strips its tag
  always_comb begin
    saved_next          = pcc_q;
    saved_next[TAG_BIT] = pcc_q[TAG_BIT] && !clear_saved_tag;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pcc_q  <= ROOT_CAP;
      epcc_q <= '0;
    end else if (trap) begin
      epcc_q <= saved_next;
      pcc_q  <= tvec_cap;
    end else if (ret) begin
      pcc_q  <= epcc_q;
    end else if (ld_valid) begin
      pcc_q  <= ld_cap;
    end
  end

endmodule

// File: rtl/cap_fetch_guard.sv
module cap_fetch_guard #(
  parameter int            AW         = 32,
  parameter int            PW         = 4,
  parameter int            CAUSE_W    = 6,
  parameter logic [AW-1:0] RESET_ADDR = 32'h0000_1000,
  localparam int           CAPW       = 3*AW + PW + 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fetch_valid,
  input  logic               fetch_is32,
  input  logic               ld_valid,
  input  logic [CAPW-1:0]    ld_cap,
  input  logic               exc_req,
  input  logic [CAUSE_W-1:0] exc_code,
  input  logic               mret_req,
  input  logic [CAPW-1:0]    tvec_cap,
  output logic [CAPW-1:0]    pcc_cap,
  output logic [CAPW-1:0]    epcc_cap,
  output logic               fault_tag,
  output logic               fault_len,
  output logic               trap_taken,
  output logic               ret_taken,
  output logic [CAUSE_W-1:0] trap_cause,
  output logic [4:0]         trap_tval
);

  localparam int ADDR_LO = 0;
  localparam int BASE_LO = AW;
  localparam int TOP_LO  = 2*AW;
  localparam int TAG_BIT = CAPW - 1;

  // Named internal events
  logic [CAPW-1:0] pcc_q;
  logic [CAPW-1:0] epcc_q;
  logic [AW-1:0]   cur_addr;
  logic [AW-1:0]   cur_base;
  logic [AW:0]     cur_top;
  logic            cur_tag;
  logic            span_ok;
  logic            trap_ev;
  logic            ret_ev;
  logic            len_fault_ev;
  logic            tag_fault_ev;

  assign cur_addr = pcc_q[ADDR_LO +: AW];
  assign cur_base = pcc_q[BASE_LO +: AW];
  assign cur_top  = pcc_q[TOP_LO  +: AW+1];
  assign cur_tag  = pcc_q[TAG_BIT];

  cfg_bounds_unit #(.AW(AW)) u_bounds (
    .addr      (cur_addr),
    .base      (cur_base),
    .top       (cur_top),
    .is32      (fetch_is32),
    .in_bounds (span_ok)
  );

  cfg_fault_sel #(.CAUSE_W(CAUSE_W)) u_sel (
    .fetch_valid (fetch_valid),
    .cap_tag     (cur_tag),
    .in_bounds   (span_ok),
    .exc_req     (exc_req),
    .exc_code    (exc_code),
    .mret_req    (mret_req),
    .fault_tag   (tag_fault_ev),
    .fault_len   (len_fault_ev),
    .trap        (trap_ev),
    .ret         (ret_ev),
    .cause       (trap_cause),
    .tval        (trap_tval)
  );

  cfg_cap_regs #(.AW(AW), .PW(PW), .RESET_ADDR(RESET_ADDR)) u_regs (
    .clk             (clk),
    .rst_n           (rst_n),
    .trap            (trap_ev),
    .ret             (ret_ev),
    .ld_valid        (ld_valid),
    .clear_saved_tag (len_fault_ev),
    .ld_cap          (ld_cap),
    .tvec_cap        (tvec_cap),
    .pcc_q           (pcc_q),
    .epcc_q          (epcc_q)
  );

  assign pcc_cap    = pcc_q;
  assign epcc_cap   = epcc_q;
  assign fault_tag  = tag_fault_ev;
  assign fault_len  = len_fault_ev;
  assign trap_taken = trap_ev;
  assign ret_taken  = ret_ev;

endmodule

// File: rtl/cap_fetch_guard_sva.sv
module cap_fetch_guard_sva #(
  parameter int AW      = 32,
  parameter int PW      = 4,
  parameter int CAUSE_W = 6,
  localparam int CAPW   = 3*AW + PW + 3,
  localparam int TAG    = CAPW - 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               fetch_valid,
  input logic               exc_req,
  input logic [CAPW-1:0]    tvec_cap,
  input logic [CAPW-1:0]    pcc_cap,
  input logic [CAPW-1:0]    epcc_cap,
  input logic               fault_tag,
  input logic               fault_len,
  input logic               trap_taken,
  input logic               ret_taken,
  input logic [CAUSE_W-1:0] trap_cause
);

  assert_tag_fault_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && !pcc_cap[TAG]) |-> (fault_tag && trap_taken && trap_cause == CAUSE_W'(8'h1C)));

  assert_fault_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fault_tag, fault_len}));

  assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_valid && !exc_req) |-> (!trap_taken && !fault_tag && !fault_len));

  assert_vector_installed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    trap_taken |=> (pcc_cap == $past(tvec_cap)));

  assert_saved_body_R6: assert property (@(posedge clk) disable iff (!rst_n)
    trap_taken |=> (epcc_cap[TAG-1:0] == $past(pcc_cap[TAG-1:0])));

  assert_len_untags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fault_len |=> !epcc_cap[TAG]);

  assert_return_install_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ret_taken |=> ((pcc_cap == $past(epcc_cap)) && $stable(epcc_cap)));

  assert_trap_over_ret_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(trap_taken && ret_taken));

endmodule

bind cap_fetch_guard cap_fetch_guard_sva #(.AW(AW), .PW(PW), .CAUSE_W(CAUSE_W)) u_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .fetch_valid (fetch_valid),
  .exc_req     (exc_req),
  .tvec_cap    (tvec_cap),
  .pcc_cap     (pcc_cap),
  .epcc_cap    (epcc_cap),
  .fault_tag   (fault_tag),
  .fault_len   (fault_len),
  .trap_taken  (trap_taken),
  .ret_taken   (ret_taken),
  .trap_cause  (trap_cause)
);

// File: tb/cap_fetch_guard_tb.sv
module cap_fetch_guard_tb;
  localparam int AW = 32, PW = 4, CAUSE_W = 6, CAPW = 3*AW + PW + 3;
  localparam logic [AW-1:0] RST_PC = 32'h0000_1000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic fetch_valid = 0, fetch_is32 = 0, ld_valid = 0, exc_req = 0, mret_req = 0;
  logic [CAPW-1:0] ld_cap = '0, tvec_cap = '0;
  logic [CAUSE_W-1:0] exc_code = '0;
  logic [CAPW-1:0] pcc_cap, epcc_cap;
  logic fault_tag, fault_len, trap_taken, ret_taken;
  logic [CAUSE_W-1:0] trap_cause;
  logic [4:0] trap_tval;

  int n_chk = 0, n_bad = 0;
  logic [CAPW-1:0] m_pcc, m_epcc;
  string state_req;

  cap_fetch_guard #(.AW(AW), .PW(PW), .CAUSE_W(CAUSE_W), .RESET_ADDR(RST_PC)) u_dut (.*);

  always #2 clk = ~clk;

  function automatic logic [CAPW-1:0] mk(input logic tg, input logic sl,
      input logic [PW-1:0] pm, input logic [AW-1:0] b, input logic [AW:0] t, input logic [AW-1:0] a);
    return {tg, sl, pm, t, b, a};
  endfunction

  function automatic logic fits(input logic [CAPW-1:0] c, input logic w);
    longint unsigned a, b, t;
    a = longint'(c[AW-1:0]); b = longint'(c[2*AW-1:AW]); t = longint'(c[3*AW:2*AW]);
    return (a >= b) && (a + (w ? 4 : 2) <= t);
  endfunction

  function automatic logic [CAPW-1:0] rnd_cap();
    logic [AW-1:0] b;
    logic [AW:0] t;
    b = $urandom;
    t = {1'b0, b} + (AW+1)'($urandom_range(0, 40));
    return mk(($urandom % 5) != 0, 1'(($urandom)), 4'($urandom), b,
              t, b + AW'($urandom_range(0, 48)) - AW'(4));
  endfunction

  task automatic chk(input string req, input string what, input logic [CAPW-1:0] act, input logic [CAPW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic fv, input logic w, input logic ld, input logic [CAPW-1:0] lc,
                      input logic ex, input logic [CAUSE_W-1:0] ec, input logic mr,
                      input logic [CAPW-1:0] tv, input string req);
    logic ft, fl, tr, rt;
    logic [CAUSE_W-1:0] ecause;
    logic [4:0] etval;
    @(negedge clk);
    chk(state_req, "pcc_cap", pcc_cap, m_pcc);
    chk(state_req, "epcc_cap", epcc_cap, m_epcc);
    fetch_valid = fv; fetch_is32 = w; ld_valid = ld; ld_cap = lc;
    exc_req = ex; exc_code = ec; mret_req = mr; tvec_cap = tv;
    #1;
    ft = fv && !m_pcc[CAPW-1];
    fl = fv && m_pcc[CAPW-1] && !fits(m_pcc, w);
    tr = ft || fl || ex;
    rt = !tr && mr;
    ecause = (ft || fl) ? 6'h1C : (ex ? ec : '0);
    etval  = ft ? 5'd2 : (fl ? 5'd1 : 5'd0);
    chk({req, ",R4"}, "fault_tag", CAPW'(fault_tag), CAPW'(ft));
    chk(req, "fault_len", CAPW'(fault_len), CAPW'(fl));
    chk(req, "trap_taken", CAPW'(trap_taken), CAPW'(tr));
    chk({req, ",R10"}, "ret_taken", CAPW'(ret_taken), CAPW'(rt));
    chk({req, ",R8"}, "trap_cause", CAPW'(trap_cause), CAPW'(ecause));
    chk(req, "trap_tval", CAPW'(trap_tval), CAPW'(etval));
    if (tr) begin
      m_epcc = m_pcc; m_epcc[CAPW-1] = m_pcc[CAPW-1] && !fl;
      m_pcc = tv; state_req = "R6,R7";
    end else if (rt) begin
      m_pcc = m_epcc; state_req = "R9";
    end else begin
      if (ld) m_pcc = lc;
      state_req = "R10";
    end
  endtask

  initial begin
    #(4*150000);
    n_bad++;
    $display("FAIL watchdog expired, run hung");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [CAPW-1:0] c, tv, utv;
    m_pcc = mk(1'b1, 1'b0, '1, '0, (AW+1)'(1) << AW, RST_PC);
    m_epcc = '0;
    state_req = "R1";
    tv  = mk(1'b1, 1'b0, '1, 32'h8000_0000, 33'h0_8000_1000, 32'h8000_0000);
    utv = mk(1'b0, 1'b0, '1, 32'h8000_0000, 33'h0_8000_1000, 32'h8000_0000);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state, then R3 legal 4-byte fetch from root
    step(1, 1, 0, '0, 0, '0, 0, tv, "R3");
    // R3 exact upper edge: addr+4 == top passes
    c = mk(1, 0, 4'hF, 32'h100, 33'h108, 32'h104);
    step(0, 0, 1, c, 0, '0, 0, tv, "R10");
    step(1, 1, 0, '0, 0, '0, 0, tv, "R3");
    c = mk(1, 0, 4'hF, 32'h100, 33'h108, 32'h106);
    step(0, 0, 1, c, 0, '0, 0, tv, "R10");
    step(1, 0, 0, '0, 0, '0, 0, tv, "R3");
    // R3/R7 4-byte fetch crossing top -> length fault, saved tag cleared
    step(1, 1, 0, '0, 0, '0, 0, tv, "R7");
    // R3 below base
    c = mk(1, 0, 4'hF, 32'h100, 33'h108, 32'hFF);
    step(0, 0, 1, c, 0, '0, 0, tv, "R10");
    step(1, 0, 0, '0, 0, '0, 0, tv, "R3");
    // R3 region ending at 2^AW: last word legal, no wrap
    c = mk(1, 0, 4'hF, 32'hFFFF_FF00, 33'h1_0000_0000, 32'hFFFF_FFFC);
    step(0, 0, 1, c, 0, '0, 0, tv, "R10");
    step(1, 1, 0, '0, 0, '0, 0, tv, "R3");
    // R4 untagged and out of bounds: tag wins; R5 first with no fetch
    c = mk(0, 0, 4'hF, 32'h100, 33'h108, 32'h200);
    step(0, 0, 1, c, 0, '0, 0, tv, "R10");
    step(0, 1, 0, '0, 0, '0, 0, tv, "R5");
    step(1, 1, 0, '0, 0, '0, 0, tv, "R4");
    // R8 external exception keeps saved tag; R9 return
    step(0, 0, 0, '0, 1, 6'h05, 0, tv, "R8");
    step(0, 0, 1, c, 0, '0, 1, tv, "R9");
    // R10 trap beats return and load
    step(0, 0, 1, c, 1, 6'h0B, 1, tv, "R10");
    // R8 fetch fault overrides exc_code
    step(0, 0, 1, c, 0, '0, 0, tv, "R10");
    step(1, 1, 0, '0, 1, 6'h0B, 0, tv, "R8");
    // R11 untagged vector loops
    step(0, 0, 0, '0, 1, 6'h02, 0, utv, "R11");
    step(1, 1, 0, '0, 0, '0, 0, utv, "R11");
    step(1, 0, 0, '0, 0, '0, 0, utv, "R11");
    step(0, 0, 0, '0, 0, '0, 0, utv, "R10");
    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic fv, ld, ex, mr;
      fv = ($urandom % 3) != 0;
      ld = ($urandom % 2) != 0;
      ex = ($urandom % 8) == 0;
      mr = ($urandom % 6) == 0;
      step(fv, 1'($urandom), ld, rnd_cap(), ex, 6'($urandom), mr, rnd_cap(), "R3");
    end
    @(negedge clk);
    chk(state_req, "pcc_cap", pcc_cap, m_pcc);
    chk(state_req, "epcc_cap", epcc_cap, m_epcc);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule